// File: doc/BRIEF.md
# Connection Memory Message-Byte Port

This block gives a host a packed view of the message bytes held in a time-slot switch connection memory. Every connection memory entry is a 16-bit control word. In message mode only its low byte matters, because that byte is the data sent on the output channel. The port exposes these low bytes four at a time. One 32-bit host access reads or sets the message bytes of four consecutive channel entries. The upper control bits of each entry are left alone.

The host address space holds a contiguous run of per-output-group windows. The block decodes a host address into a group and a memory row. It then reads the four-entry row from the connection memory and merges the enabled host byte lanes into the low bytes. It writes the row back and answers the host with a single-cycle response. Reads take the same path and return the four low bytes in big-endian lane order. Addresses outside every group window never reach the memory and read back as zero.

Top module: `cmb_byte_port`

## Requirements
- R1: While rst_ni is low, and after its release until the first request, busy_o, rsp_valid_o, mem_re_o and mem_we_o are low and rdata_o is zero.
- R2: With the default parameters the window starts at 0x2000. It holds 6 groups of 0x400 bytes each, in group order. Group g covers 0x2000+g*0x400 to 0x2000+g*0x400+0x3FF. Address bits 1:0 are ignored. The memory row driven on mem_addr_o is (addr_i-0x2000)>>2.
- R3: Lane order is big-endian. Host bits 31:24 belong to entry 4*row+0, which sits in mem bits 15:0. Bits 23:16 belong to entry +1 (mem bits 31:16). Bits 15:8 belong to entry +2 (mem bits 47:32). Bits 7:0 belong to entry +3 (mem bits 63:48). be_i bit i covers host bits 8i+7:8i.
- R4: A write changes only bits 7:0 of an entry. Bits 15:8 of all four entries in the row are written back exactly as they were read.
- R5: Only entries whose byte enable is set take the host byte. An entry whose enable is clear keeps its old low byte, including when be_i is zero.
- R6: A read in the window returns the four low bytes on rdata_o, in the lane order of R3.
- R7: An access outside the window asserts neither mem_re_o nor mem_we_o. It still produces a response, with rdata_o equal to zero.
- R8: A request is accepted on a rising edge. mem_re_o is high for the one cycle after acceptance. rsp_valid_o is a one-cycle pulse two cycles after acceptance. For an in-window write, mem_we_o is high in that same cycle, carrying the row address that was read. rdata_o is zero on a write response.
- R9: busy_o is high for the two cycles after acceptance. Requests seen while busy_o is high are ignored and cause no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Host byte address |
| be_i | input | 4 | Host byte enables, bit i covers data bits 8i+7:8i |
| wdata_i | input | 32 | Host write data |
| busy_o | output | 1 | Access in flight, new requests ignored |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rdata_o | output | 32 | Packed message bytes for a read response |
| mem_re_o | output | 1 | Connection memory row read strobe |
| mem_we_o | output | 1 | Connection memory row write strobe |
| mem_addr_o | output | 11 | Connection memory row address |
| mem_wdata_o | output | 64 | Merged row, four 16-bit entries |
| mem_rdata_i | input | 64 | Row data, valid the cycle after mem_re_o |

## Verification
Each access runs on a fixed timeline counted from its accepting edge. The row read strobe and busy_o are due one edge later, and busy_o is still high after the second. The response, the read data and the row write are due after the second edge. The memory holds the merged row after the third. The bench raises the request on a falling edge and samples on each of the next four falling edges. At each one it compares every output against the value the model predicts for that cycle, so a result one cycle early or late is caught. The model is an entry-level shadow array, and each written row is compared with it once the write has landed.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned ENTRY_W = 16;
  localparam int unsigned MSG_W   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2
  } cmb_state_e;

  // set on the control bits (15:8) of every entry in a row
  function automatic logic [LANES*ENTRY_W-1:0] upper_mask();
    logic [LANES*ENTRY_W-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      m[k*ENTRY_W+MSG_W +: ENTRY_W-MSG_W] = '1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cmb_addr_decode.sv
module cmb_addr_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WIN_BASE   = 'h2000,
  parameter int unsigned NUM_GROUPS = 6,
  parameter int unsigned SPAN_LOG2  = 10,
  parameter int unsigned GRP_W      = 3,
  parameter int unsigned ROW_W      = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ROW_W-1:0]  row_o
);
  localparam int unsigned TOP_W = ADDR_W - SPAN_LOG2;

  logic [ADDR_W-1:0] off;
  logic [TOP_W-1:0]  grp;
  logic              unused_lsb;

  always_comb begin
    off   = addr_i - ADDR_W'(WIN_BASE);
    grp   = off[ADDR_W-1:SPAN_LOG2];
    hit_o = (addr_i >= ADDR_W'(WIN_BASE)) && (grp < TOP_W'(NUM_GROUPS));
    row_o = {grp[GRP_W-1:0], off[SPAN_LOG2-1:2]};
  end

  assign unused_lsb = ^off[1:0];
endmodule

// File: rtl/cmb_lane_merge.sv
module cmb_lane_merge
  import cmb_pkg::*;
(
  input  logic [LANES*ENTRY_W-1:0] row_i,
  input  logic [LANES*MSG_W-1:0]   wdata_i,
  input  logic [LANES-1:0]         be_i,
  output logic [LANES*ENTRY_W-1:0] row_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned H = LANES - 1 - k;  // big-endian host lane
    assign row_o[k*ENTRY_W+MSG_W +: ENTRY_W-MSG_W] = row_i[k*ENTRY_W+MSG_W +: ENTRY_W-MSG_W];
    assign row_o[k*ENTRY_W +: MSG_W] = be_i[H] ? wdata_i[H*MSG_W +: MSG_W]
                                               : row_i[k*ENTRY_W +: MSG_W];
  end
endmodule

// File: rtl/cmb_lane_pack.sv
module cmb_lane_pack
  import cmb_pkg::*;
(
  input  logic [LANES*ENTRY_W-1:0] row_i,
  output logic [LANES*MSG_W-1:0]   data_o
);
  logic [LANES-1:0] unused_hi;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned H = LANES - 1 - k;
    assign data_o[H*MSG_W +: MSG_W] = row_i[k*ENTRY_W +: MSG_W];
    assign unused_hi[k] = ^row_i[k*ENTRY_W+MSG_W +: ENTRY_W-MSG_W];
  end
endmodule

// File: rtl/cmb_byte_port.sv
module cmb_byte_port
  import cmb_pkg::*;
#(
  parameter  int unsigned ADDR_W     = 16,
  parameter  int unsigned WIN_BASE   = 'h2000,
  parameter  int unsigned NUM_GROUPS = 6,
  parameter  int unsigned SPAN_LOG2  = 10,
  localparam int unsigned GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int unsigned ROW_W      = GRP_W + SPAN_LOG2 - 2,
  localparam int unsigned HOST_W     = LANES * MSG_W,
  localparam int unsigned ROWDATA_W  = LANES * ENTRY_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [LANES-1:0]     be_i,
  input  logic [HOST_W-1:0]    wdata_i,
  output logic                 busy_o,
  output logic                 rsp_valid_o,
  output logic [HOST_W-1:0]    rdata_o,
  output logic                 mem_re_o,
  output logic                 mem_we_o,
  output logic [ROW_W-1:0]     mem_addr_o,
  output logic [ROWDATA_W-1:0] mem_wdata_o,
  input  logic [ROWDATA_W-1:0] mem_rdata_i
);
  localparam logic [ROWDATA_W-1:0] UPPER_MASK = upper_mask();

  cmb_state_e          state_q;
  logic                dec_hit;
  logic [ROW_W-1:0]    dec_row;
  logic                hit_q, we_q;
  logic [LANES-1:0]    be_q;
  logic [HOST_W-1:0]   wdata_q;
  logic [ROWDATA_W-1:0] merged_row;
  logic [HOST_W-1:0]   packed_bytes;

  cmb_addr_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .NUM_GROUPS(NUM_GROUPS),
    .SPAN_LOG2 (SPAN_LOG2),
    .GRP_W     (GRP_W),
    .ROW_W     (ROW_W)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (dec_hit),
    .row_o (dec_row)
  );

  cmb_lane_merge u_merge (
    .row_i  (mem_rdata_i),
    .wdata_i(wdata_q),
    .be_i   (be_q),
    .row_o  (merged_row)
  );

  cmb_lane_pack u_pack (
    .row_i (mem_rdata_i),
    .data_o(packed_bytes)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hit_q       <= 1'b0;
      we_q        <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      mem_re_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      mem_re_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q  <= ST_READ;
          hit_q    <= dec_hit;
          we_q     <= we_i;
          be_q     <= be_i;
          wdata_q  <= wdata_i;
          mem_re_o <= dec_hit;
          if (dec_hit) mem_addr_o <= dec_row;
        end
        ST_READ: state_q <= ST_MERGE;
        ST_MERGE: begin
          state_q     <= ST_IDLE;
          rsp_valid_o <= 1'b1;
          rdata_o     <= (hit_q && !we_q) ? packed_bytes : '0;
          if (hit_q && we_q) begin
            mem_we_o    <= 1'b1;
            mem_wdata_o <= merged_row;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  wr_follows_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(mem_re_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));

  // R4
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_wdata_o & UPPER_MASK) == ($past(mem_rdata_i) & UPPER_MASK)));

  // R9
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> $past(req_i && !busy_o));

  // R7
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(mem_re_o, 2)) |-> (!mem_we_o && rdata_o == '0));
endmodule

// File: tb/tb_cmb_byte_port.sv
module tb_cmb_byte_port;
  localparam int BASE = 'h2000;
  localparam int NG   = 6;
  localparam int ROWS = NG * 256;
  localparam int ENTS = ROWS * 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, we;
  logic [15:0] addr;
  logic [3:0]  be;
  logic [31:0] wdata, rdata;
  logic        busy, rsp, mre, mwe;
  logic [10:0] maddr;
  logic [63:0] mwdata, mrdata;

  logic [63:0] mem [ROWS];
  logic [15:0] sh  [ENTS];
  int n_chk = 0, n_fail = 0;

  cmb_byte_port dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .busy_o(busy), .rsp_valid_o(rsp),
    .rdata_o(rdata), .mem_re_o(mre), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  // connection memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mre && int'(maddr) < ROWS) mrdata <= mem[maddr];
    if (mwe && int'(maddr) < ROWS) mem[maddr] <= mwdata;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [3:0] b,
                        input logic [31:0] d, input bit poke);
    bit hit;
    int r;
    logic [31:0] exp_rd;
    hit = (int'(a) >= BASE) && (int'(a) < BASE + NG * 1024);
    r = hit ? ((int'(a) - BASE) >> 2) : 0;
    exp_rd = '0;
    if (hit && !w)
      for (int k = 0; k < 4; k++) exp_rd[31-8*k -: 8] = sh[4*r+k][7:0];
    @(negedge clk);
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    chk("R9 busy after accept", busy, 1);
    chk("R8 read strobe", mre, hit);
    chk("R8 no early rsp", rsp, 0);
    if (hit) chk("R2 row address", maddr, r);
    if (poke) begin
      req = 1'b1; we = 1'b1; addr = 16'h2100; be = 4'hF; wdata = 32'hDEADBEEF;
    end else req = 1'b0;
    @(negedge clk);
    chk("R9 busy second cycle", busy, 1);
    chk("R8 read strobe single", mre, 0);
    chk("R8 no early rsp", rsp, 0);
    req = 1'b0;
    @(negedge clk);
    chk("R8 rsp due", rsp, 1);
    chk("R9 idle at rsp", busy, 0);
    chk("R8 R7 write strobe", mwe, hit && w);
    chk(w ? "R8 write rdata zero" : (hit ? "R6 read data" : "R7 miss reads zero"), rdata, exp_rd);
    if (hit && w) begin
      chk("R8 write row", maddr, r);
      for (int k = 0; k < 4; k++)
        if (b[3-k]) sh[4*r+k][7:0] = d[31-8*k -: 8];
    end
    @(negedge clk);
    chk("R8 rsp single", rsp, 0);
    chk("R8 write single", mwe, 0);
    chk("R9 busy request ignored", mre, 0);
    if (hit)
      for (int k = 0; k < 4; k++) chk("R4 R5 row contents", mem[r][16*k +: 16], sh[4*r+k]);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    for (int e = 0; e < ENTS; e++) sh[e] = 16'(e * 40503 + 4660);
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < 4; k++) mem[r][16*k +: 16] = sh[4*r+k];
    mrdata = '0;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; be = '0; wdata = '0;
    #20;
    chk("R1 busy in reset", busy, 0);
    chk("R1 rsp in reset", rsp, 0);
    chk("R1 strobes in reset", {mre, mwe}, 0);
    chk("R1 rdata in reset", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {busy, rsp, mre, mwe}, 0);

    access(1, 16'h2000, 4'hF, 32'hA1B2C3D4, 0);
    chk("R3 bits 31:24 to entry 0", mem[0][7:0], 8'hA1);
    chk("R3 bits 7:0 to entry 3", mem[0][55:48], 8'hD4);
    access(0, 16'h2000, 4'h0, 0, 0);
    access(1, 16'h37FC, 4'b0101, 32'h11223344, 0);  // R5 last group, last word
    access(0, 16'h37FC, 4'h0, 0, 0);
    access(1, 16'h2403, 4'b1000, 32'h5A000000, 0);  // R2 low bits ignored
    access(0, 16'h2400, 4'h0, 0, 0);
    access(1, 16'h2C10, 4'h0, 32'hFFFFFFFF, 0);     // R5 no enables
    access(0, 16'h2C10, 4'h0, 0, 0);
    access(1, 16'h1FFC, 4'hF, 32'hCAFEF00D, 0);     // R7 below window
    access(1, 16'h3800, 4'hF, 32'hCAFEF00D, 0);     // R7 above window
    access(0, 16'h3800, 4'h0, 0, 0);
    access(0, 16'h2200, 4'h0, 0, 1);                // R9 poke while busy
    access(0, 16'h2100, 4'h0, 0, 0);
    for (int i = 0; i < 300; i++)
      access(1'($urandom_range(0, 1)), 16'($urandom_range(32'h1F80, 32'h3880)),
             4'($urandom), $urandom, 0);
    bad = 0;
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < 4; k++)
        if (mem[r][16*k +: 16] !== sh[4*r+k]) bad++;
    chk("R4 R7 whole memory", 64'(bad), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule